// File: doc/BRIEF.md
# High/Low Cycle Programmable Clock Divider

This block divides an incoming clock by any integer from 2 to 32. The lengths of the low and high phases of the divided clock are set separately. Each phase is a 4-bit field that holds the phase length in input cycles minus one, so the duty cycle can be asymmetric. The whole period is the sum of both phase lengths. A bypass setting hands the input clock straight to the output (divide-by-1) and parks the counters.

A duty-cycle correction stage is active unless its disable bit is set. For odd ratios whose low field is one more than the high field, it adds half an input period to the high phase. The result is an exact 50% output. When correction is requested but the fields do not have a correctable shape, the block keeps the uncorrected waveform and raises a fallback flag.

A synchronisation pulse, or reset, pulls the output low and captures the configuration. The first low phase is lengthened by a programmable number of whole input cycles, so several dividers can be aligned with chosen offsets. Configuration changes are ignored between sync pulses, which prevents runt pulses while the divider runs. All pins are plain level signals. There is no data stream, so no valid/ready handshake applies.

Top module: `hl_clock_divider`

## Requirements
- R1: With correction inactive (disable bit set, or fallback), the output is low for lo_len+1 input cycles and high for hi_len+1 input cycles in steady state.
- R2: For every one of the 256 pairs of 4-bit lo_len/hi_len values (0 to 15), the output period is lo_len+hi_len+2 input cycles, covering ratios 2 to 32.
- R3: When the captured bypass bit is 1, clk_out equals clk_in, the internal phase register stays low, and dcc_fallback is 0.
- R4: Correction is active when cfg_dcc_off is 0. An even ratio with lo_len equal to hi_len gives equal high and low phases.
- R5: With correction active and lo_len equal to hi_len+1 (an odd ratio R), the high and low phases each last R half input periods.
- R6: dcc_fallback is 1 exactly when correction is active, bypass is 0, and lo_len is neither hi_len nor hi_len+1. The flag changes only at a reset or sync capture. In that case the waveform is the R1 waveform.
- R7: At the clk_in rising edge that samples sync_pulse high, clk_out goes low and stays low for cfg_phase+lo_len+1 input cycles (with the correction stretch not in use). It is then high for hi_len+1 cycles.
- R8: Configuration inputs are captured only at an edge where rst or sync_pulse is 1. Changes at any other time have no effect on clk_out or dcc_fallback.
- R9: While rst is 1 and cfg_bypass is 0, clk_out is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst | input | 1 | Active-high synchronous reset; also captures configuration |
| sync_pulse | input | 1 | Restarts the divider and captures configuration |
| cfg_lo_len | input | 4 | Low phase length minus one, in input cycles |
| cfg_hi_len | input | 4 | High phase length minus one, in input cycles |
| cfg_bypass | input | 1 | 1 = output follows input (divide-by-1) |
| cfg_dcc_off | input | 1 | 1 = duty-cycle correction disabled |
| cfg_phase | input | PHASE_W | Extra input cycles added to the first low phase after sync |
| clk_out | output | 1 | Divided clock |
| dcc_fallback | output | 1 | Correction requested but field shape not correctable |

## Verification
A corrupted phase counter shows up at the ports within one output period as a high or low run of the wrong length. The bench therefore measures run lengths in half input periods over every lo/hi pair, with correction both on and off. A wrong half-period stretch register changes the high run by exactly one half period, and that run is measured in the same pass. Errors in configuration capture appear after the first sync, as a first low run that is too long or too short, or as a flag or waveform that follows inputs changed without a sync.

// File: rtl/hlcd_pkg.sv
package hlcd_pkg;
  localparam int FIELD_W = 4;

  typedef logic [FIELD_W-1:0] field_t;

  typedef struct packed {
    field_t lo_len;
    field_t hi_len;
    logic   bypass;
    logic   dcc_off;
  } cfg_t;

  // low field exactly one above high field: odd ratio, stretchable
  function automatic logic lo_is_hi_plus1(field_t lo, field_t hi);
    logic [FIELD_W:0] hi_inc;
    hi_inc = {1'b0, hi} + {{FIELD_W{1'b0}}, 1'b1};
    return ({1'b0, lo} == hi_inc);
  endfunction

  // shapes the correction stage can deliver at 50%
  function automatic logic shape_correctable(field_t lo, field_t hi);
    return (lo == hi) || lo_is_hi_plus1(lo, hi);
  endfunction
endpackage

// File: rtl/hlcd_cfg_hold.sv
module hlcd_cfg_hold
  import hlcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  // capture only on reset or sync; frozen otherwise
  always_ff @(posedge clk) begin
    if (rst || sync) begin
      cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/hlcd_phase_gen.sv
module hlcd_phase_gen
  import hlcd_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync,
  input  field_t             load_lo,
  input  logic [PHASE_W-1:0] load_phase,
  input  field_t             lo_q,
  input  field_t             hi_q,
  input  logic               bypass_q,
  output logic               hi_pos
);
  localparam int MAXW  = (PHASE_W > FIELD_W) ? PHASE_W : FIELD_W;
  localparam int CNT_W = MAXW + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || sync) begin
      // first low phase carries the start offset
      hi_pos <= 1'b0;
      cnt    <= CNT_W'(load_phase) + CNT_W'(load_lo);
    end else if (bypass_q) begin
      hi_pos <= 1'b0;
    end else if (cnt == '0) begin
      hi_pos <= ~hi_pos;
      cnt    <= hi_pos ? CNT_W'(lo_q) : CNT_W'(hi_q);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/hlcd_dcc.sv
module hlcd_dcc
  import hlcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   hi_pos,
  input  field_t lo_q,
  input  field_t hi_q,
  input  logic   bypass_q,
  input  logic   dcc_off_q,
  output logic   div_out,
  output logic   fallback
);
  logic hi_neg;
  logic corr_req;
  logic stretch_en;

  // half-period delayed copy of the high phase
  always_ff @(negedge clk) begin
    if (rst) begin
      hi_neg <= 1'b0;
    end else begin
      hi_neg <= hi_pos;
    end
  end

  always_comb begin
    corr_req   = !dcc_off_q && !bypass_q;
    stretch_en = corr_req && lo_is_hi_plus1(lo_q, hi_q);
    fallback   = corr_req && !shape_correctable(lo_q, hi_q);
    div_out    = hi_pos | (stretch_en & hi_neg);
  end
endmodule

// File: rtl/hl_clock_divider.sv
module hl_clock_divider
  import hlcd_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk_in,
  input  logic               rst,
  input  logic               sync_pulse,
  input  logic [FIELD_W-1:0] cfg_lo_len,
  input  logic [FIELD_W-1:0] cfg_hi_len,
  input  logic               cfg_bypass,
  input  logic               cfg_dcc_off,
  input  logic [PHASE_W-1:0] cfg_phase,
  output logic               clk_out,
  output logic               dcc_fallback
);
  cfg_t cfg_in;
  cfg_t cfg_q;
  logic hi_pos;
  logic div_out;

  always_comb begin
    cfg_in.lo_len  = cfg_lo_len;
    cfg_in.hi_len  = cfg_hi_len;
    cfg_in.bypass  = cfg_bypass;
    cfg_in.dcc_off = cfg_dcc_off;
  end

  hlcd_cfg_hold u_cfg (
    .clk    (clk_in),
    .rst    (rst),
    .sync   (sync_pulse),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  hlcd_phase_gen #(.PHASE_W(PHASE_W)) u_gen (
    .clk        (clk_in),
    .rst        (rst),
    .sync       (sync_pulse),
    .load_lo    (cfg_lo_len),
    .load_phase (cfg_phase),
    .lo_q       (cfg_q.lo_len),
    .hi_q       (cfg_q.hi_len),
    .bypass_q   (cfg_q.bypass),
    .hi_pos     (hi_pos)
  );

  hlcd_dcc u_dcc (
    .clk       (clk_in),
    .rst       (rst),
    .hi_pos    (hi_pos),
    .lo_q      (cfg_q.lo_len),
    .hi_q      (cfg_q.hi_len),
    .bypass_q  (cfg_q.bypass),
    .dcc_off_q (cfg_q.dcc_off),
    .div_out   (div_out),
    .fallback  (dcc_fallback)
  );

  assign clk_out = cfg_q.bypass ? clk_in : div_out;
endmodule

// File: rtl/hl_clock_divider_checker.sv
module hl_clock_divider_checker #(
  parameter int PHASE_W = 4
) (
  input logic               clk_in,
  input logic               rst,
  input logic               sync_pulse,
  input logic [3:0]         cfg_lo_len,
  input logic [3:0]         cfg_hi_len,
  input logic               cfg_bypass,
  input logic [PHASE_W-1:0] cfg_phase,
  input logic               hi_pos,
  input logic [3:0]         lo_q,
  input logic [3:0]         hi_q,
  input logic               dcc_fallback
);
  localparam int RUN_W = PHASE_W + 6;

  logic [3:0]         c_lo, c_hi;
  logic [PHASE_W-1:0] c_ph;
  logic               c_byp;
  logic [RUN_W-1:0]   hi_run, lo_run;
  logic               seen_rise;

  always_ff @(posedge clk_in) begin
    if (rst || sync_pulse) begin
      c_lo      <= cfg_lo_len;
      c_hi      <= cfg_hi_len;
      c_ph      <= cfg_phase;
      c_byp     <= cfg_bypass;
      hi_run    <= '0;
      lo_run    <= '0;
      seen_rise <= 1'b0;
    end else begin
      seen_rise <= seen_rise | hi_pos;
      if (hi_pos) begin
        hi_run <= hi_run + 1'b1;
        lo_run <= '0;
      end else begin
        lo_run <= lo_run + 1'b1;
        hi_run <= '0;
      end
    end
  end

  // R1: steady high run length
  a_r1_high_len: assert property (@(posedge clk_in) disable iff (rst)
    ($fell(hi_pos) && !$past(sync_pulse)) |-> (int'(hi_run) == int'(c_hi) + 1));

  // R1: steady low run length
  a_r1_low_len: assert property (@(posedge clk_in) disable iff (rst)
    ($rose(hi_pos) && seen_rise) |-> (int'(lo_run) == int'(c_lo) + 1));

  // R7: first low run after sync includes offset
  a_r7_first_low: assert property (@(posedge clk_in) disable iff (rst)
    ($rose(hi_pos) && !seen_rise) |-> (int'(lo_run) == int'(c_ph) + int'(c_lo) + 1));

  // R3: counters parked in bypass
  a_r3_bypass_idle: assert property (@(posedge clk_in) disable iff (rst)
    c_byp |-> !hi_pos);

  // R6: flag changes only on capture
  a_r6_flag_on_load: assert property (@(posedge clk_in) disable iff (rst)
    (dcc_fallback != $past(dcc_fallback)) |-> $past(sync_pulse));

  // R8: captured fields frozen without sync
  a_r8_cfg_hold: assert property (@(posedge clk_in) disable iff (rst)
    !sync_pulse |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

bind hl_clock_divider hl_clock_divider_checker #(.PHASE_W(PHASE_W)) u_chk (
  .clk_in       (clk_in),
  .rst          (rst),
  .sync_pulse   (sync_pulse),
  .cfg_lo_len   (cfg_lo_len),
  .cfg_hi_len   (cfg_hi_len),
  .cfg_bypass   (cfg_bypass),
  .cfg_phase    (cfg_phase),
  .hi_pos       (hi_pos),
  .lo_q         (cfg_q.lo_len),
  .hi_q         (cfg_q.hi_len),
  .dcc_fallback (dcc_fallback)
);

// File: tb/hl_clock_divider_bench.sv
module hl_clock_divider_bench;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sync = 1'b0;
  logic [3:0]    lo_len = 4'd3;
  logic [3:0]    hi_len = 4'd3;
  logic          byp = 1'b0;
  logic          off = 1'b0;
  logic [PW-1:0] ph = '0;
  logic          clk_out;
  logic          flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  hl_clock_divider #(.PHASE_W(PW)) u_hl_clock_divider (
    .clk_in(clk), .rst(rst), .sync_pulse(sync),
    .cfg_lo_len(lo_len), .cfg_hi_len(hi_len), .cfg_bypass(byp),
    .cfg_dcc_off(off), .cfg_phase(ph),
    .clk_out(clk_out), .dcc_fallback(flag)
  );

  // {lo[22:19], hi[18:15], off[14], byp[13], exp_hi[12:7], exp_lo[6:1], exp_flag[0]}
  localparam logic [22:0] VEC [8] = '{
    {4'd0,  4'd0,  1'b0, 1'b0, 6'd2,  6'd2,  1'b0},
    {4'd15, 4'd15, 1'b0, 1'b0, 6'd32, 6'd32, 1'b0},
    {4'd1,  4'd0,  1'b0, 1'b0, 6'd3,  6'd3,  1'b0},
    {4'd1,  4'd0,  1'b1, 1'b0, 6'd2,  6'd4,  1'b0},
    {4'd15, 4'd14, 1'b0, 1'b0, 6'd31, 6'd31, 1'b0},
    {4'd3,  4'd7,  1'b0, 1'b0, 6'd16, 6'd8,  1'b1},
    {4'd0,  4'd1,  1'b0, 1'b0, 6'd4,  6'd2,  1'b1},
    {4'd5,  4'd5,  1'b0, 1'b1, 6'd1,  6'd1,  1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic half(output logic v);
    @(clk);
    #5;
    v = clk_out;
  endtask

  // steady-state high and low run lengths in half input periods
  task automatic measure(output int hi, output int lo);
    logic prev, v;
    int   len, ends;
    hi = -1; lo = -1; ends = 0;
    half(prev);
    len = 1;
    for (int i = 0; i < 700 && (hi < 0 || lo < 0); i++) begin
      half(v);
      if (v == prev) len++;
      else begin
        ends++;
        if (ends > 3) begin
          if (prev) hi = len; else lo = len;
        end
        prev = v;
        len  = 1;
      end
    end
  endtask

  task automatic apply(input logic [3:0] l, input logic [3:0] h,
                       input logic o, input logic b, input logic [PW-1:0] p);
    @(negedge clk);
    lo_len = l; hi_len = h; off = o; byp = b; ph = p;
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [22:0] vv;
    int mh, ml, eh, el, lowc, highc;
    logic v;
    logic ef;

    // R9: reset holds output low
    repeat (3) @(posedge clk);
    #5 chk(clk_out == 1'b0, "R9 reset high-half", int'(clk_out), 0);
    @(negedge clk);
    #5 chk(clk_out == 1'b0, "R9 reset low-half", int'(clk_out), 0);
    chk(flag == 1'b0, "R6 flag in reset", int'(flag), 0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: R1 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      vv = VEC[i];
      apply(vv[22:19], vv[18:15], vv[14], vv[13], '0);
      chk(flag == vv[0], $sformatf("table %0d flag R6", i), int'(flag), int'(vv[0]));
      measure(mh, ml);
      chk(mh == int'(vv[12:7]), $sformatf("table %0d high R1 R3 R4 R5", i), mh, int'(vv[12:7]));
      chk(ml == int'(vv[6:1]),  $sformatf("table %0d low R1 R3 R4 R5", i),  ml, int'(vv[6:1]));
    end

    // R2 sweep, correction on and off
    for (int l = 0; l < 16; l++) begin
      for (int h = 0; h < 16; h++) begin
        for (int o = 0; o < 2; o++) begin
          apply(4'(l), 4'(h), 1'(o), 1'b0, '0);
          ef = (o == 0) && !(l == h || l == h + 1);
          if (o == 0 && l == h + 1) begin
            eh = l + h + 2; el = l + h + 2;
          end else begin
            eh = 2 * (h + 1); el = 2 * (l + 1);
          end
          chk(flag == ef, $sformatf("R6 flag lo=%0d hi=%0d off=%0d", l, h, o), int'(flag), int'(ef));
          measure(mh, ml);
          chk(mh + ml == 2 * (l + h + 2) && mh == eh,
              $sformatf("R2 high lo=%0d hi=%0d off=%0d", l, h, o), mh, eh);
          chk(ml == el, $sformatf("R2 low lo=%0d hi=%0d off=%0d", l, h, o), ml, el);
        end
      end
    end

    // R7: start offset after sync
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (k == 0) begin lo_len = 4'd2; hi_len = 4'd1; ph = 4'd5; end
      else begin lo_len = 4'd0; hi_len = 4'd2; ph = 4'd0; end
      off = 1'b1; byp = 1'b0; sync = 1'b1;
      @(posedge clk);
      #5;
      sync = 1'b0;
      v = clk_out;
      lowc = 0; highc = 0;
      while (!v && lowc < 200) begin lowc++; half(v); end
      while (v && highc < 200) begin highc++; half(v); end
      chk(lowc == 2 * (int'(ph) + int'(lo_len) + 1), "R7 first low", lowc,
          2 * (int'(ph) + int'(lo_len) + 1));
      chk(highc == 2 * (int'(hi_len) + 1), "R7 first high", highc, 2 * (int'(hi_len) + 1));
    end

    // R8: inputs changed without sync are ignored
    apply(4'd3, 4'd3, 1'b0, 1'b0, '0);
    @(negedge clk);
    lo_len = 4'd0; hi_len = 4'd9; off = 1'b0; byp = 1'b1;
    measure(mh, ml);
    chk(mh == 8, "R8 high unchanged", mh, 8);
    chk(ml == 8, "R8 low unchanged", ml, 8);
    chk(flag == 1'b0, "R8 flag unchanged", int'(flag), 0);

    // R3: bypass clears flag even with bad shape
    apply(4'd3, 4'd7, 1'b0, 1'b1, '0);
    chk(flag == 1'b0, "R3 flag in bypass", int'(flag), 0);
    measure(mh, ml);
    chk(mh == 1 && ml == 1, "R3 bypass follows input", mh * 100 + ml, 101);

    summary();
  end
endmodule